// File: doc/BRIEF.md
# 8b/10b Transmit Symbol Path

This block sits between a link-layer transmit byte stream and a 10-bit serializer. On each clock it accepts one byte and a flag marking it as a control character. It turns the byte into a 10-bit 8b/10b symbol and keeps the running disparity up to date from the symbols it actually sends. A per-byte compliance input makes the current symbol go out as if the running disparity were negative, whatever the tracked state is. This is what a compliance pattern built from K28.5 symbols needs.

Two other sources can take over the output. A loopback enable sends already-received 10-bit symbols back out in place of the encoded ones. A transmit-idle input blanks the output for electrical idle. All selections and the encoded symbol are captured in one register stage, so the output is a registered 10-bit symbol with a valid qualifier and an encode-error pulse.

Top module: `tx_symbol_path`

## Requirements
- R1: After reset, `sym_o` is 0, `sym_vld_o` is 0 and `enc_err_o` is 0, and the running disparity is negative. The first K28.5 sent after reset is therefore 10'h0FA.
- R2: A data byte HGF_EDCBA (byte bits 7..0) is encoded to standard 8b/10b. The 6-bit sub-block abcdei sits on `sym_o[9:4]` with a on bit 9. The 4-bit sub-block fghj sits on `sym_o[3:0]` with f on bit 3. Examples: D0.0 at negative disparity is 10'h274, D24.3 at negative disparity is 10'h333, D14.7 at positive disparity is 10'h1C8.
- R3: Running disparity is updated after every encoded symbol according to the disparity that symbol actually carried. K28.5 sent twice in a row alternates 10'h0FA and 10'h305.
- R4: With `tx_compl_i` high on an encoded byte, the symbol is encoded from negative disparity regardless of the tracked state. K28.5 marked this way is always 10'h0FA.
- R5: After a forced symbol, the running disparity follows the symbol that was sent. After a forced K28.5 it is positive, so an unforced K28.5 next gives 10'h305.
- R6: While `tx_idle_i` is high, the output is `sym_o`=0 with `sym_vld_o`=0 and `enc_err_o`=0, and the running disparity is held. Idle has priority over loopback and encoding.
- R7: While `lpbk_en_i` is high and idle is low, `sym_o` equals `lpbk_sym_i` with `sym_vld_o`=1 and `enc_err_o`=0. Running disparity is held, and compliance and transmit bytes have no effect.
- R8: The accepted control codes are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7, and they encode to standard symbols (K23.7 at negative disparity is 10'h3A8, K28.7 at negative disparity is 10'h0F8). A control flag on any other byte raises `enc_err_o` for that one symbol only, and the byte is sent as its data code.
- R9: The output changes exactly one clock after the controlling input changes, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_byte_i | input | 8 | Transmit byte |
| tx_ctl_i | input | 1 | Byte is a control character |
| tx_compl_i | input | 1 | Encode this byte from negative disparity |
| tx_idle_i | input | 1 | Hold electrical idle |
| lpbk_en_i | input | 1 | Send looped-back symbols instead of encoded bytes |
| lpbk_sym_i | input | 10 | Received 10-bit symbol for loopback |
| sym_o | output | 10 | Registered 10-bit symbol to the serializer |
| sym_vld_o | output | 1 | Symbol valid; low during electrical idle |
| enc_err_o | output | 1 | One-cycle pulse: control flag on a non-control byte |

## Verification
A wrong running-disparity bit inside this block does not stay hidden. It shows at the ports on the next unbalanced symbol that gets encoded, as the complemented code: 10'h305 where 10'h0FA was due, for instance. For that reason the stimulus sends unforced K28.5 symbols right after the forced, idle and loopback phases, and right after reset, since any of those could leave the state wrong. A wrong choice between idle, loopback and encoding, or an error flag left set, is visible on the very next symbol.

// File: rtl/tx_sym_pkg.sv
package tx_sym_pkg;
  localparam int BYTE_W = 8;
  localparam int SYM_W  = 10;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_LOOP = 2'd1,
    SEL_ENC  = 2'd2
  } tx_sel_e;
endpackage

// File: rtl/tx_sym_enc6.sv
// 5b/6b sub-block encoder. rd_i/rd_o: 1 = positive running disparity.
module tx_sym_enc6 (
  input  logic [4:0] x_i,
  input  logic       k28_i,
  input  logic       rd_i,
  output logic [5:0] code_o,
  output logic       rd_o
);
  logic [5:0] base;
  logic       keep;

  always_comb begin
    unique case (x_i)
      5'd0:  base = 6'b100111;
      5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;
      5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;
      5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;
      5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;
      5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;
      5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;
      5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;
      5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;
      5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;
      5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;
      5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;
      5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;
      5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;
      5'd27: base = 6'b110110;
      5'd28: base = k28_i ? 6'b001111 : 6'b001110;
      5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;
      default: base = 6'b101011;
    endcase
    // Balanced codes are shared by both disparities, except the 111000/000111 pair.
    keep   = ($countones(base) == 3) && (base != 6'b111000);
    code_o = (rd_i && !keep) ? ~base : base;
    rd_o   = rd_i ^ ($countones(code_o) != 3);
  end
endmodule

// File: rtl/tx_sym_enc4.sv
// 3b/4b sub-block encoder. alt_i selects the alternate x.7 code.
module tx_sym_enc4 (
  input  logic [2:0] y_i,
  input  logic       k28_i,
  input  logic       alt_i,
  input  logic       rd_i,
  output logic [3:0] code_o,
  output logic       rd_o
);
  logic [3:0] base;
  logic       flip;
  logic [3:0] pos_code;

  always_comb begin
    unique case (y_i)
      3'd0: base = 4'b1011;
      3'd1: base = 4'b1001;
      3'd2: base = 4'b0101;
      3'd3: base = 4'b1100;
      3'd4: base = 4'b1101;
      3'd5: base = 4'b1010;
      3'd6: base = 4'b0110;
      default: base = alt_i ? 4'b0111 : 4'b1110;
    endcase
    flip     = ($countones(base) != 2) || (y_i == 3'd3);
    pos_code = flip ? ~base : base;
    if (k28_i) begin
      // K28 sub-blocks always mirror with disparity.
      code_o = pos_code ^ {4{~rd_i}};
    end else begin
      code_o = rd_i ? pos_code : base;
    end
    rd_o = rd_i ^ ($countones(code_o) != 2);
  end
endmodule

// File: rtl/tx_sym_encoder.sv
module tx_sym_encoder
  import tx_sym_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ctl_i,
  input  logic              rd_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              rd_o,
  output logic              kerr_o
);
  logic [4:0] x;
  logic [2:0] y;
  logic       k_ok;
  logic       k28;
  logic       alt;
  logic [5:0] c6;
  logic [3:0] c4;
  logic       rd_mid;

  assign x = byte_i[4:0];
  assign y = byte_i[7:5];

  always_comb begin
    k_ok = ctl_i && ((x == 5'd28) ||
           ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30))));
    k28    = k_ok && (x == 5'd28);
    kerr_o = ctl_i && !k_ok;
  end

  tx_sym_enc6 u_enc6 (
    .x_i    (x),
    .k28_i  (k28),
    .rd_i   (rd_i),
    .code_o (c6),
    .rd_o   (rd_mid)
  );

  // Alternate x.7 avoids a run of five equal bits across the sub-block edge.
  assign alt = (y == 3'd7) &&
               (k_ok || (!rd_mid && c6[1] && c6[0]) || (rd_mid && !c6[1] && !c6[0]));

  tx_sym_enc4 u_enc4 (
    .y_i    (y),
    .k28_i  (k28),
    .alt_i  (alt),
    .rd_i   (rd_mid),
    .code_o (c4),
    .rd_o   (rd_o)
  );

  assign sym_o = {c6, c4};
endmodule

// File: rtl/tx_symbol_path.sv
module tx_symbol_path
  import tx_sym_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_ctl_i,
  input  logic              tx_compl_i,
  input  logic              tx_idle_i,
  input  logic              lpbk_en_i,
  input  logic [SYM_W-1:0]  lpbk_sym_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              sym_vld_o,
  output logic              enc_err_o
);
  // Reset: asserted asynchronously, released through a synchronizer chain.
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n;

  generate
    if (RST_STAGES == 1) begin : g_rst1
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) rst_sync_q <= '0;
        else          rst_sync_q <= 1'b1;
      end
    end else begin : g_rstn
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) rst_sync_q <= '0;
        else          rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_n = rst_sync_q[RST_STAGES-1];

  tx_sel_e            sel;
  logic               rd_q;
  logic               rd_en;
  logic               enc_rd_in;
  logic               enc_rd_out;
  logic [SYM_W-1:0]   enc_sym;
  logic               enc_kerr;
  logic [SYM_W-1:0]   sym_nxt;
  logic               vld_nxt;
  logic               err_nxt;
  logic               armed_q;

  // Compliance forces negative starting disparity for this symbol only.
  assign enc_rd_in = tx_compl_i ? 1'b0 : rd_q;

  tx_sym_encoder u_enc (
    .byte_i (tx_byte_i),
    .ctl_i  (tx_ctl_i),
    .rd_i   (enc_rd_in),
    .sym_o  (enc_sym),
    .rd_o   (enc_rd_out),
    .kerr_o (enc_kerr)
  );

  always_comb begin
    if (tx_idle_i)      sel = SEL_IDLE;
    else if (lpbk_en_i) sel = SEL_LOOP;
    else                sel = SEL_ENC;

    sym_nxt = enc_sym;
    vld_nxt = 1'b1;
    err_nxt = enc_kerr;
    unique case (sel)
      SEL_IDLE: begin
        sym_nxt = '0;
        vld_nxt = 1'b0;
        err_nxt = 1'b0;
      end
      SEL_LOOP: begin
        sym_nxt = lpbk_sym_i;
        err_nxt = 1'b0;
      end
      default: ;
    endcase
    rd_en = (sel == SEL_ENC);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sym_o     <= '0;
      sym_vld_o <= 1'b0;
      enc_err_o <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      sym_o     <= sym_nxt;
      sym_vld_o <= vld_nxt;
      enc_err_o <= err_nxt;
      armed_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     rd_q <= 1'b0;
    else if (rd_en) rd_q <= enc_rd_out;
  end

  // R6: idle one cycle earlier blanks the symbol and its qualifier.
  a_r6_idle_blank: assert property (@(posedge clk_i) disable iff (!rst_n)
    armed_q && $past(tx_idle_i) |-> !sym_vld_o && (sym_o == '0) && !enc_err_o);

  // R7: loopback passes the received symbol through unchanged.
  a_r7_loop_pass: assert property (@(posedge clk_i) disable iff (!rst_n)
    armed_q && $past(!tx_idle_i && lpbk_en_i)
    |-> sym_vld_o && (sym_o == $past(lpbk_sym_i)) && !enc_err_o);

  // R4: a K28.5 marked for compliance leaves as the negative-disparity code.
  a_r4_compl_k285: assert property (@(posedge clk_i) disable iff (!rst_n)
    armed_q && $past(!tx_idle_i && !lpbk_en_i && tx_compl_i && tx_ctl_i && (tx_byte_i == 8'hBC))
    |-> sym_o == 10'h0FA);

  // R2: every encoded symbol carries four, five or six ones.
  a_r2_weight: assert property (@(posedge clk_i) disable iff (!rst_n)
    armed_q && $past(!tx_idle_i && !lpbk_en_i) |-> ($countones(sym_o) inside {4, 5, 6}));

  // R8: the error pulse only follows an encoded byte that carried the control flag.
  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_n)
    armed_q && $past(tx_idle_i || lpbk_en_i || !tx_ctl_i) |-> !enc_err_o);
endmodule

// File: tb/tx_symbol_path_tb.sv
`timescale 1ns/1ps
module tx_symbol_path_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_byte;
  logic       tx_ctl, tx_compl, tx_idle, lpbk_en;
  logic [9:0] lpbk_sym;
  logic [9:0] sym;
  logic       vld, err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tx_symbol_path dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .tx_byte_i  (tx_byte),
    .tx_ctl_i   (tx_ctl),
    .tx_compl_i (tx_compl),
    .tx_idle_i  (tx_idle),
    .lpbk_en_i  (lpbk_en),
    .lpbk_sym_i (lpbk_sym),
    .sym_o      (sym),
    .sym_vld_o  (vld),
    .enc_err_o  (err)
  );

  // {idle, lpbk, compl, ctl, byte[8], lpsym[10], exp_vld, exp_sym[10], exp_err}
  localparam int NV = 23;
  localparam logic [33:0] VEC [NV] = '{
    {4'b0001, 8'hBC, 10'h000, 1'b1, 10'h0FA, 1'b0}, //  0 R1 first K28.5 at negative
    {4'b0001, 8'hBC, 10'h000, 1'b1, 10'h305, 1'b0}, //  1 R3 alternates
    {4'b0000, 8'h00, 10'h000, 1'b1, 10'h274, 1'b0}, //  2 R2 D0.0-
    {4'b0000, 8'hB5, 10'h000, 1'b1, 10'h2AA, 1'b0}, //  3 R2 D21.5
    {4'b0000, 8'h07, 10'h000, 1'b1, 10'h38B, 1'b0}, //  4 R2 D7.0-
    {4'b0000, 8'hF1, 10'h000, 1'b1, 10'h231, 1'b0}, //  5 R3 D17.7+
    {4'b0000, 8'hF1, 10'h000, 1'b1, 10'h237, 1'b0}, //  6 R3 D17.7- alternate
    {4'b0011, 8'hBC, 10'h000, 1'b1, 10'h0FA, 1'b0}, //  7 R4 forced at positive
    {4'b0011, 8'hBC, 10'h000, 1'b1, 10'h0FA, 1'b0}, //  8 R4 forced again
    {4'b0001, 8'hBC, 10'h000, 1'b1, 10'h305, 1'b0}, //  9 R5 follows sent
    {4'b1001, 8'hBC, 10'h000, 1'b0, 10'h000, 1'b0}, // 10 R6 idle
    {4'b0001, 8'hBC, 10'h000, 1'b1, 10'h0FA, 1'b0}, // 11 R6 disparity held
    {4'b0111, 8'h00, 10'h155, 1'b1, 10'h155, 1'b0}, // 12 R7 loopback
    {4'b1100, 8'h00, 10'h2AB, 1'b0, 10'h000, 1'b0}, // 13 R6 idle over loopback
    {4'b0001, 8'hBC, 10'h000, 1'b1, 10'h305, 1'b0}, // 14 R7 disparity held
    {4'b0001, 8'h00, 10'h000, 1'b1, 10'h274, 1'b1}, // 15 R8 invalid K
    {4'b0001, 8'hF7, 10'h000, 1'b1, 10'h3A8, 1'b0}, // 16 R8 K23.7
    {4'b0001, 8'hFC, 10'h000, 1'b1, 10'h0F8, 1'b0}, // 17 R8 K28.7
    {4'b0001, 8'h3C, 10'h000, 1'b1, 10'h0F9, 1'b0}, // 18 R8 K28.1-
    {4'b0001, 8'h3C, 10'h000, 1'b1, 10'h306, 1'b0}, // 19 R8 K28.1+
    {4'b0000, 8'h4A, 10'h000, 1'b1, 10'h155, 1'b0}, // 20 R2 D10.2
    {4'b0000, 8'h78, 10'h000, 1'b1, 10'h333, 1'b0}, // 21 R2 D24.3-
    {4'b0000, 8'hEE, 10'h000, 1'b1, 10'h1C8, 1'b0}  // 22 R2 D14.7+
  };

  function automatic string req_of(int i);
    if (i == 0)      return "R1";
    if (i == 1)      return "R3";
    if (i <= 4)      return "R2";
    if (i <= 6)      return "R3";
    if (i <= 8)      return "R4";
    if (i == 9)      return "R5";
    if (i <= 11)     return "R6";
    if (i == 12)     return "R7";
    if (i == 13)     return "R6";
    if (i == 14)     return "R7";
    if (i <= 19)     return "R8";
    return "R2";
  endfunction

  task automatic check(string req, logic [9:0] es, logic ev, logic ee);
    checks++;
    if (sym !== es || vld !== ev || err !== ee) begin
      errors++;
      $display("FAIL %s: sym=%h vld=%b err=%b expected sym=%h vld=%b err=%b",
               req, sym, vld, err, es, ev, ee);
    end
  endtask

  task automatic drive(logic [33:0] v);
    tx_idle  = v[33];
    lpbk_en  = v[32];
    tx_compl = v[31];
    tx_ctl   = v[30];
    tx_byte  = v[29:22];
    lpbk_sym = v[21:12];
  endtask

  task automatic drive_k285();
    drive({4'b0001, 8'hBC, 10'h000, 12'h000});
  endtask

  initial begin
    rst_n = 1'b0;
    drive({4'b1000, 8'h00, 10'h000, 12'h000});
    repeat (3) @(negedge clk);
    check("R1", 10'h000, 1'b0, 1'b0);          // R1 reset state
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", 10'h000, 1'b0, 1'b0);          // idle before first symbol

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(req_of(i), VEC[i][10:1], VEC[i][11], VEC[i][0]);
    end

    // R9: no change before the edge, change right after it.
    drive({4'b1000, 8'h00, 10'h000, 12'h000});
    #2;
    check("R9", 10'h1C8, 1'b1, 1'b0);
    @(negedge clk);
    check("R9", 10'h000, 1'b0, 1'b0);

    // R1: reset in mid-stream restores negative disparity.
    drive_k285();
    @(negedge clk);
    check("R3", 10'h0FA, 1'b1, 1'b0);          // disparity now positive
    #2 rst_n = 1'b0;
    #1 check("R1", 10'h000, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", 10'h000, 1'b0, 1'b0);          // held through release
    @(negedge clk);
    check("R1", 10'h0FA, 1'b1, 1'b0);          // negative again after reset

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: sym=%h vld=%b expected completion", sym, vld);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule